// File: doc/BRIEF.md
# Broadcast Bus Interconnect with Priority Acknowledge Chain

This block joins a single upstream bus port, driven by the CPU, to a parameterised number of downstream ports that lead to memories and peripherals. Every downstream port receives the same address, write data and transfer strobes as the upstream port. Read data and reply flags coming back from the downstream ports are merged into one upstream read path. Each downstream device drives zeros on its read data whenever it is not addressed.

Interrupt requests from the downstream ports are merged into one upstream request. The interrupt acknowledge passes through the ports one after another, in index order. A port that is requesting an interrupt keeps the acknowledge, so the ports behind it never see it. This fixes a priority in which a lower index wins. The winning device then returns its vector through the normal read path.

Interrupt request and acknowledge are active-low. The datapath is purely combinational. The clock and reset inputs are kept only so that pipelining can be added later.

Top module: `bcast_icon`

## Requirements
- R1: The number of downstream ports is set by `NPORT`, in the range 1 to 11. Every downstream vector output carries exactly `NPORT` slices. Port k occupies bits [k*AW +: AW] or [k*DW +: DW], or bit k for single-bit signals.
- R2: Every downstream address slice and every downstream write-data slice equals the upstream address and the upstream write data.
- R3: The four strobes (address valid, read request, write request, byte-write qualifier) are copied unchanged to every downstream port.
- R4: The upstream read data is the bitwise OR of all downstream read-data slices.
- R5: The upstream reply is high exactly when at least one downstream reply is high.
- R6: The upstream interrupt request (active-low) is low exactly when at least one downstream request is low.
- R7: Downstream port 0 receives the upstream acknowledge (active-low) unchanged.
- R8: Port k+1 receives the acknowledge level of port k while port k is not requesting (its request is high). While port k is requesting, port k+1 receives the inactive level 1.
- R9: When several ports request at the same time and the acknowledge is active, only the lowest-index requester sees an active acknowledge.
- R10: No output depends on the clock or on reset. Outputs follow the inputs while reset is held and with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, reserved for future pipelining |
| rst_ni | input | 1 | Active-low reset, reserved |
| up_addr_i | input | AW | Upstream address |
| up_wdata_i | input | DW | Upstream write data |
| up_rdata_o | output | DW | Merged read data |
| up_sync_i | input | 1 | Address-valid strobe |
| up_rply_o | output | 1 | Merged reply |
| up_rd_i | input | 1 | Read request strobe |
| up_wr_i | input | 1 | Write request strobe |
| up_wbyte_i | input | 1 | Byte-write qualifier |
| up_ack_ni | input | 1 | Interrupt acknowledge, active-low |
| up_irq_no | output | 1 | Merged interrupt request, active-low |
| dn_addr_o | output | NPORT*AW | Per-port address |
| dn_wdata_o | output | NPORT*DW | Per-port write data |
| dn_rdata_i | input | NPORT*DW | Per-port read data |
| dn_sync_o | output | NPORT | Per-port address-valid strobe |
| dn_rply_i | input | NPORT | Per-port reply |
| dn_rd_o | output | NPORT | Per-port read strobe |
| dn_wr_o | output | NPORT | Per-port write strobe |
| dn_wbyte_o | output | NPORT | Per-port byte qualifier |
| dn_ack_no | output | NPORT | Per-port acknowledge, active-low |
| dn_irq_ni | input | NPORT | Per-port interrupt request, active-low |

## Verification
The bench builds two copies of the block.

The first copy uses the maximum of 11 ports. With it, a request at the far end of the chain, requests near the head and several simultaneous requests can all be placed against the full length of the acknowledge path.

The second copy uses a single port. It covers the degenerate chain, where the acknowledge and request pass straight through and the merge trees collapse to one input.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
    localparam int unsigned MAX_PORTS = 11;

    // Transfer strobes copied from upstream to each downstream port
    typedef struct packed {
        logic sync;
        logic rd;
        logic wr;
        logic wbyte;
    } strb_t;
endpackage

// File: rtl/bcast_fanout.sv
module bcast_fanout
    import bcast_pkg::*;
#(
    parameter int unsigned NPORT = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16
) (
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    input  strb_t               strb_i,
    output logic [NPORT*AW-1:0] addr_o,
    output logic [NPORT*DW-1:0] wdata_o,
    output strb_t [NPORT-1:0]   strb_o
);
    for (genvar k = 0; k < NPORT; k++) begin : g_port
        assign addr_o[k*AW +: AW]  = addr_i;
        assign wdata_o[k*DW +: DW] = wdata_i;
        assign strb_o[k]           = strb_i;
    end
endmodule

// File: rtl/bcast_merge.sv
module bcast_merge #(
    parameter int unsigned NPORT = 4,
    parameter int unsigned DW    = 16
) (
    input  logic [NPORT*DW-1:0] rdata_i,
    input  logic [NPORT-1:0]    rply_i,
    input  logic [NPORT-1:0]    irq_ni,
    output logic [DW-1:0]       rdata_o,
    output logic                rply_o,
    output logic                irq_no
);
    // Unselected slaves drive zeros, so a plain OR tree forms the read mux
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NPORT; k++) begin
            rdata_o = rdata_o | rdata_i[k*DW +: DW];
        end
    end

    assign rply_o = |rply_i;
    assign irq_no = &irq_ni;   // any active-low request pulls it low
endmodule

// File: rtl/bcast_ackchain.sv
module bcast_ackchain #(
    parameter int unsigned NPORT = 4
) (
    input  logic             ack_ni,
    input  logic [NPORT-1:0] irq_ni,
    output logic [NPORT-1:0] ack_no
);
    // Walk the chain with a running level; a requester forces inactive (1) onward
    always_comb begin
        logic pass_n;
        pass_n = ack_ni;
        for (int k = 0; k < NPORT; k++) begin
            ack_no[k] = pass_n;
            pass_n    = pass_n | ~irq_ni[k];
        end
    end
endmodule

// File: rtl/bcast_icon.sv
module bcast_icon
    import bcast_pkg::*;
#(
    parameter int unsigned NPORT = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [AW-1:0]       up_addr_i,
    input  logic [DW-1:0]       up_wdata_i,
    output logic [DW-1:0]       up_rdata_o,
    input  logic                up_sync_i,
    output logic                up_rply_o,
    input  logic                up_rd_i,
    input  logic                up_wr_i,
    input  logic                up_wbyte_i,
    input  logic                up_ack_ni,
    output logic                up_irq_no,
    output logic [NPORT*AW-1:0] dn_addr_o,
    output logic [NPORT*DW-1:0] dn_wdata_o,
    input  logic [NPORT*DW-1:0] dn_rdata_i,
    output logic [NPORT-1:0]    dn_sync_o,
    input  logic [NPORT-1:0]    dn_rply_i,
    output logic [NPORT-1:0]    dn_rd_o,
    output logic [NPORT-1:0]    dn_wr_o,
    output logic [NPORT-1:0]    dn_wbyte_o,
    output logic [NPORT-1:0]    dn_ack_no,
    input  logic [NPORT-1:0]    dn_irq_ni
);
    if (NPORT < 1 || NPORT > MAX_PORTS) begin : g_bad_count
        $error("bcast_icon: NPORT out of range");
    end

    strb_t              up_strb_d;
    strb_t [NPORT-1:0]  dn_strb_d;

    assign up_strb_d = '{sync: up_sync_i, rd: up_rd_i, wr: up_wr_i, wbyte: up_wbyte_i};

    bcast_fanout #(.NPORT(NPORT), .AW(AW), .DW(DW)) u_fanout (
        .addr_i  (up_addr_i),
        .wdata_i (up_wdata_i),
        .strb_i  (up_strb_d),
        .addr_o  (dn_addr_o),
        .wdata_o (dn_wdata_o),
        .strb_o  (dn_strb_d)
    );

    for (genvar k = 0; k < NPORT; k++) begin : g_strb
        assign dn_sync_o[k]  = dn_strb_d[k].sync;
        assign dn_rd_o[k]    = dn_strb_d[k].rd;
        assign dn_wr_o[k]    = dn_strb_d[k].wr;
        assign dn_wbyte_o[k] = dn_strb_d[k].wbyte;
    end

    bcast_merge #(.NPORT(NPORT), .DW(DW)) u_merge (
        .rdata_i (dn_rdata_i),
        .rply_i  (dn_rply_i),
        .irq_ni  (dn_irq_ni),
        .rdata_o (up_rdata_o),
        .rply_o  (up_rply_o),
        .irq_no  (up_irq_no)
    );

    bcast_ackchain #(.NPORT(NPORT)) u_chain (
        .ack_ni (up_ack_ni),
        .irq_ni (dn_irq_ni),
        .ack_no (dn_ack_no)
    );
endmodule

// File: rtl/bcast_icon_chk.sv
module bcast_icon_chk #(
    parameter int unsigned NPORT = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [AW-1:0]       up_addr_i,
    input logic [DW-1:0]       up_wdata_i,
    input logic [DW-1:0]       up_rdata_o,
    input logic                up_sync_i,
    input logic                up_rply_o,
    input logic                up_rd_i,
    input logic                up_wr_i,
    input logic                up_wbyte_i,
    input logic                up_ack_ni,
    input logic                up_irq_no,
    input logic [NPORT*AW-1:0] dn_addr_o,
    input logic [NPORT*DW-1:0] dn_wdata_o,
    input logic [NPORT*DW-1:0] dn_rdata_i,
    input logic [NPORT-1:0]    dn_sync_o,
    input logic [NPORT-1:0]    dn_rply_i,
    input logic [NPORT-1:0]    dn_rd_o,
    input logic [NPORT-1:0]    dn_wr_o,
    input logic [NPORT-1:0]    dn_wbyte_o,
    input logic [NPORT-1:0]    dn_ack_no,
    input logic [NPORT-1:0]    dn_irq_ni
);
    for (genvar k = 0; k < NPORT; k++) begin : g_chk
        assert_fanout_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            dn_addr_o[k*AW +: AW] == up_addr_i && dn_wdata_o[k*DW +: DW] == up_wdata_i);
        assert_strobes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            {dn_sync_o[k], dn_rd_o[k], dn_wr_o[k], dn_wbyte_o[k]} ==
            {up_sync_i, up_rd_i, up_wr_i, up_wbyte_i});
        // A set rdata bit on any port must appear upstream
        assert_rdata_cover_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dn_rdata_i[k*DW +: DW] & ~up_rdata_o) == '0);
        if (k > 0) begin : g_link
            assert_chain_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !dn_ack_no[k] |-> (!dn_ack_no[k-1] && dn_irq_ni[k-1]));
        end
    end

    assert_rply_any_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dn_rply_i != '0) |-> up_rply_o);
    assert_rply_none_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dn_rply_i == '0) |-> !up_rply_o);
    assert_irq_merge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dn_irq_ni != '1) |-> !up_irq_no);
    assert_irq_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dn_irq_ni == '1) |-> up_irq_no);
    assert_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dn_ack_no[0] == up_ack_ni);
    assert_idle_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_ack_ni |-> (dn_ack_no == '1));
    assert_one_winner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~dn_ack_no & ~dn_irq_ni));
endmodule

bind bcast_icon bcast_icon_chk #(.NPORT(NPORT), .AW(AW), .DW(DW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_addr_i  (up_addr_i),
    .up_wdata_i (up_wdata_i),
    .up_rdata_o (up_rdata_o),
    .up_sync_i  (up_sync_i),
    .up_rply_o  (up_rply_o),
    .up_rd_i    (up_rd_i),
    .up_wr_i    (up_wr_i),
    .up_wbyte_i (up_wbyte_i),
    .up_ack_ni  (up_ack_ni),
    .up_irq_no  (up_irq_no),
    .dn_addr_o  (dn_addr_o),
    .dn_wdata_o (dn_wdata_o),
    .dn_rdata_i (dn_rdata_i),
    .dn_sync_o  (dn_sync_o),
    .dn_rply_i  (dn_rply_i),
    .dn_rd_o    (dn_rd_o),
    .dn_wr_o    (dn_wr_o),
    .dn_wbyte_o (dn_wbyte_o),
    .dn_ack_no  (dn_ack_no),
    .dn_irq_ni  (dn_irq_ni)
);

// File: tb/sim_bcast_icon.sv
module sim_bcast_icon;
    localparam int NP = 11;
    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // wide instance
    logic [AW-1:0]    up_addr, up_wdata;
    logic [DW-1:0]    up_rdata;
    logic             up_sync, up_rd, up_wr, up_wbyte, up_ack_n, up_rply, up_irq_n;
    logic [NP*AW-1:0] dn_addr;
    logic [NP*DW-1:0] dn_wdata, dn_rdata;
    logic [NP-1:0]    dn_sync, dn_rply, dn_rd, dn_wr, dn_wbyte, dn_ack_n, dn_irq_n;

    bcast_icon #(.NPORT(NP), .AW(AW), .DW(DW)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .up_addr_i(up_addr), .up_wdata_i(up_wdata), .up_rdata_o(up_rdata),
        .up_sync_i(up_sync), .up_rply_o(up_rply), .up_rd_i(up_rd), .up_wr_i(up_wr),
        .up_wbyte_i(up_wbyte), .up_ack_ni(up_ack_n), .up_irq_no(up_irq_n),
        .dn_addr_o(dn_addr), .dn_wdata_o(dn_wdata), .dn_rdata_i(dn_rdata),
        .dn_sync_o(dn_sync), .dn_rply_i(dn_rply), .dn_rd_o(dn_rd), .dn_wr_o(dn_wr),
        .dn_wbyte_o(dn_wbyte), .dn_ack_no(dn_ack_n), .dn_irq_ni(dn_irq_n)
    );

    // single-port instance
    logic [DW-1:0] s_rdata_o, s_rdata_i, s_wdata_o;
    logic [AW-1:0] s_addr_o;
    logic          s_rply_o, s_irq_o, s_sync, s_rd, s_wr, s_wb, s_ack_o;
    logic          s_rply_i, s_irq_i;

    bcast_icon #(.NPORT(1), .AW(AW), .DW(DW)) u1 (
        .clk_i(clk), .rst_ni(rst_n),
        .up_addr_i(up_addr), .up_wdata_i(up_wdata), .up_rdata_o(s_rdata_o),
        .up_sync_i(up_sync), .up_rply_o(s_rply_o), .up_rd_i(up_rd), .up_wr_i(up_wr),
        .up_wbyte_i(up_wbyte), .up_ack_ni(up_ack_n), .up_irq_no(s_irq_o),
        .dn_addr_o(s_addr_o), .dn_wdata_o(s_wdata_o), .dn_rdata_i(s_rdata_i),
        .dn_sync_o(s_sync), .dn_rply_i(s_rply_i), .dn_rd_o(s_rd), .dn_wr_o(s_wr),
        .dn_wbyte_o(s_wb), .dn_ack_no(s_ack_o), .dn_irq_ni(s_irq_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Acknowledge-chain vectors; bit k = port k; request and acknowledge active-low
    typedef struct packed {
        logic          ack_n;
        logic [10:0]   irq_n;
        logic [10:0]   exp_ack;
        logic          exp_irq;
        logic [15:0]   addr;
        logic [15:0]   wd;
        logic [3:0]    strb;   // sync, rd, wr, wbyte
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 11'h7FF, 11'h000, 1'b1, 16'h0000, 16'hFFFF, 4'b1000},
        '{1'b0, 11'h7FE, 11'h7FE, 1'b0, 16'h1234, 16'h5678, 4'b1100},
        '{1'b0, 11'h7FB, 11'h7F8, 1'b0, 16'hFFFF, 16'h0000, 4'b1010},
        '{1'b0, 11'h3FF, 11'h000, 1'b0, 16'hA5A5, 16'h5A5A, 4'b1011},
        '{1'b1, 11'h7FE, 11'h7FF, 1'b0, 16'h8001, 16'h7FFE, 4'b0001},
        '{1'b0, 11'h5EF, 11'h7E0, 1'b0, 16'hC000, 16'h0003, 4'b0110},
        '{1'b0, 11'h000, 11'h7FE, 1'b0, 16'h00FF, 16'hFF00, 4'b1111},
        '{1'b0, 11'h7DF, 11'h7C0, 1'b0, 16'h0F0F, 16'hF0F0, 4'b0000}
    };

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        up_addr = '0; up_wdata = '0; up_sync = 0; up_rd = 0; up_wr = 0; up_wbyte = 0;
        up_ack_n = 1'b1; dn_rdata = '0; dn_rply = '0; dn_irq_n = '1;
        s_rdata_i = '0; s_rply_i = 0; s_irq_i = 1'b1;

        // R10: outputs follow inputs during reset, without clock edges
        #2;
        check("R10 idle irq in reset", {63'd0, up_irq_n}, 64'd1);
        check("R10 idle ack in reset", {53'd0, dn_ack_n}, {53'd0, 11'h7FF});
        up_addr = 16'hBEEF; dn_rdata[3*DW +: DW] = 16'h0042; dn_irq_n = 11'h7FD;
        #1;
        check("R10 addr in reset", {48'd0, dn_addr[10*AW +: AW]}, 64'hBEEF);
        check("R10 rdata in reset", {48'd0, up_rdata}, 64'h0042);
        check("R10 irq in reset", {63'd0, up_irq_n}, 64'd0);
        dn_rdata = '0; dn_irq_n = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        foreach (VEC[i]) begin
            @(negedge clk);
            up_ack_n = VEC[i].ack_n; dn_irq_n = VEC[i].irq_n;
            up_addr = VEC[i].addr; up_wdata = VEC[i].wd;
            {up_sync, up_rd, up_wr, up_wbyte} = VEC[i].strb;
            #1;
            check("R8 R9 ack chain", {53'd0, dn_ack_n}, {53'd0, VEC[i].exp_ack});
            check("R7 head ack", {63'd0, dn_ack_n[0]}, {63'd0, VEC[i].ack_n});
            check("R6 irq merge", {63'd0, up_irq_n}, {63'd0, VEC[i].exp_irq});
            for (int k = 0; k < NP; k++) begin
                check("R2 fanout", {32'd0, dn_addr[k*AW +: AW], dn_wdata[k*DW +: DW]},
                      {32'd0, VEC[i].addr, VEC[i].wd});
                check("R3 strobes", {60'd0, dn_sync[k], dn_rd[k], dn_wr[k], dn_wbyte[k]},
                      {60'd0, VEC[i].strb});
            end
            check("R1 port slice count", {32'd0, $bits(dn_addr)}, {32'd0, NP*AW});
        end

        // R4: read data merge
        @(negedge clk);
        dn_rdata = '0; #1;
        check("R4 no data", {48'd0, up_rdata}, 64'd0);
        dn_rdata[10*DW +: DW] = 16'h8421; #1;
        check("R4 last port", {48'd0, up_rdata}, 64'h8421);
        dn_rdata[0 +: DW] = 16'h0F0F; #1;
        check("R4 two ports OR", {48'd0, up_rdata}, 64'h8F2F);
        dn_rdata = '0;

        // R5: reply merge
        dn_rply = '0; #1;
        check("R5 no reply", {63'd0, up_rply}, 64'd0);
        dn_rply = 11'h400; #1;
        check("R5 last port reply", {63'd0, up_rply}, 64'd1);
        dn_rply = 11'h001; #1;
        check("R5 first port reply", {63'd0, up_rply}, 64'd1);
        dn_rply = '0;

        // single-port instance: R1 R4 R5 R6 R7
        @(negedge clk);
        up_ack_n = 1'b0; s_irq_i = 1'b0; s_rdata_i = 16'h1357; s_rply_i = 1'b1; #1;
        check("R7 single ack", {63'd0, s_ack_o}, 64'd0);
        check("R6 single irq", {63'd0, s_irq_o}, 64'd0);
        check("R4 single rdata", {48'd0, s_rdata_o}, 64'h1357);
        check("R5 single rply", {63'd0, s_rply_o}, 64'd1);
        check("R1 single width", {32'd0, $bits(s_addr_o)}, {32'd0, AW});
        up_ack_n = 1'b1; s_irq_i = 1'b1; s_rply_i = 1'b0; #1;
        check("R7 single idle", {63'd0, s_ack_o}, 64'd1);
        check("R5 single none", {63'd0, s_rply_o}, 64'd0);

        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule